// File: doc/BRIEF.md
# Byte-Stuffed Frame Receiver with Destination Filter

This block sits behind a serial receiver on a shared multi-drop bus. It takes one received byte at a time. It removes the byte-stuffing used by SLIP framing and decides, from the first decoded byte, whether the frame is meant for this node. Frames for this node, and frames sent to the broadcast address, are forwarded byte by byte. Every other frame is dropped as it arrives, so it never takes up storage. A node that is busy for a long time therefore only has to buffer the traffic that concerns it.

A decoded frame holds four parts in this order: the destination byte, the source byte, any number of payload bytes, and one check byte. The block passes on every decoded byte of an accepted frame, the check byte included. The last forwarded byte of a frame carries a last flag. In the same cycle the block gives a one-cycle frame report with the decoded length and a good flag. The next stage, which stores the frame, uses the good flag to keep or discard it. A frame with a bad check is never answered; it is only reported as not good. The escape decoding, the address match, the length limit and the check are all computed as the bytes go past.

Top module: `slip_addr_filter`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `dout_valid`, `dout_last` and `frm_done` are low.
- R2: Byte 0xC0 closes a frame. A 0xC0 that arrives with no decoded byte since the previous 0xC0 produces no forwarded byte and no frame report.
- R3: The escape pair 0xDB 0xDC yields one decoded byte 0xC0. The 0xDB on its own yields nothing.
- R4: The escape pair 0xDB 0xDD yields one decoded byte 0xDB.
- R5: Two cases make an accepted frame illegal: an escape byte followed by any byte other than 0xDC, 0xDD or 0xC0, or an escape byte directly followed by the closing 0xC0. Such a frame is still reported, with `frm_ok` low. The bad pair adds no decoded byte.
- R6: A frame whose first decoded byte equals `node_addr` is forwarded with all of its decoded bytes, in order. The last byte has `dout_last` high, and `frm_done` is high in that same cycle. `frm_len` is the number of decoded bytes.
- R7: A frame whose first decoded byte equals `BCAST_ADDR` (default 0xFF) is accepted in the same way as in R6.
- R8: A frame whose first decoded byte matches neither address produces no `dout_valid` and no `frm_done`, up to and including its closing 0xC0.
- R9: `frm_ok` is high only when the 8-bit sum of all decoded bytes of the frame, check byte included, is zero, and no other rule marks the frame bad.
- R10: An accepted frame of fewer than 3 decoded bytes is reported with `frm_ok` low.
- R11: When decoded byte number `MAX_LEN`+1 of an accepted frame arrives, the frame is closed at once. Byte `MAX_LEN` is forwarded with `dout_last`, and the report has `frm_len` = `MAX_LEN` and `frm_ok` low. All later bytes up to the next 0xC0 are ignored, and no second report is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| node_addr | input | 8 | Address of this node |
| rx_byte | input | 8 | Raw received byte |
| rx_valid | input | 1 | `rx_byte` holds a new byte this cycle |
| dout_byte | output | 8 | Decoded byte of an accepted frame |
| dout_valid | output | 1 | `dout_byte` is valid |
| dout_last | output | 1 | `dout_byte` is the final byte of its frame |
| frm_done | output | 1 | One-cycle frame report strobe |
| frm_len | output | $clog2(MAX_LEN+1) | Decoded byte count of the reported frame |
| frm_ok | output | 1 | Reported frame passed all checks |

## Verification
The destination byte is swept over all 256 values with an otherwise fixed, well-checked frame. This tells apart the node match, the broadcast match and silent rejection, and it also exercises escaped address values. A sweep of frame lengths from one byte to beyond `MAX_LEN` covers both sides of the minimum length and of the length limit, once with a correct check byte and once with a corrupted one. Runs of back-to-back 0xC0, frames whose data contain 0xC0 and 0xDB, and frames with an illegal escape or an escape right before the closing byte separate the empty-frame rule, correct unescaping and the protocol-error path.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam logic [7:0] SLIP_END     = 8'hC0;
    localparam logic [7:0] SLIP_ESC     = 8'hDB;
    localparam logic [7:0] SLIP_ESC_END = 8'hDC;
    localparam logic [7:0] SLIP_ESC_ESC = 8'hDD;

    // One decoded event from the unescape stage
    typedef struct packed {
        logic       vld;   // decoded data byte present
        logic [7:0] data;
        logic       eof;   // frame delimiter seen
        logic       bad;   // illegal escape pair
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // waiting for destination byte
        ST_ACCEPT = 2'd1,  // forwarding a frame for us
        ST_SKIP   = 2'd2   // discarding until delimiter
    } flt_state_e;

    function automatic logic addr_hit(input logic [7:0] dst,
                                      input logic [7:0] mine,
                                      input logic [7:0] bcast);
        return (dst == mine) || (dst == bcast);
    endfunction

endpackage

// File: rtl/sdf_unescape.sv
module sdf_unescape
    import sdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output dec_t       dec_o
);

    logic esc_q;
    dec_t dec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_q <= 1'b0;
            dec_q <= '0;
        end else begin
            dec_q <= '0;
            if (in_valid) begin
                if (in_byte == SLIP_END) begin
                    dec_q.eof <= 1'b1;
                    dec_q.bad <= esc_q;     // escape cut short by delimiter
                    esc_q     <= 1'b0;
                end else if (esc_q) begin
                    esc_q <= 1'b0;
                    if (in_byte == SLIP_ESC_END) begin
                        dec_q.vld  <= 1'b1;
                        dec_q.data <= SLIP_END;
                    end else if (in_byte == SLIP_ESC_ESC) begin
                        dec_q.vld  <= 1'b1;
                        dec_q.data <= SLIP_ESC;
                    end else begin
                        dec_q.bad <= 1'b1;
                    end
                end else if (in_byte == SLIP_ESC) begin
                    esc_q <= 1'b1;
                end else begin
                    dec_q.vld  <= 1'b1;
                    dec_q.data <= in_byte;
                end
            end
        end
    end

    assign dec_o = dec_q;

    AST_ESC_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte == SLIP_ESC && !esc_q) |=> !dec_q.vld); // R3

endmodule

// File: rtl/sdf_filter.sv
module sdf_filter
    import sdf_pkg::*;
#(
    parameter int         MAX_LEN    = 64,
    parameter logic [7:0] BCAST_ADDR = 8'hFF,
    parameter int         LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       node_addr,
    input  dec_t             dec_i,
    output logic [7:0]       out_byte_o,
    output logic             out_valid_o,
    output logic             out_last_o,
    output logic             eof_valid_o,
    output logic [LEN_W-1:0] eof_len_o,
    output logic             eof_good_o
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(3);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    flt_state_e       st_q;
    logic [LEN_W-1:0] cnt_q;
    logic [7:0]       sum_q;
    logic             err_q;
    logic [7:0]       held_q;   // one-byte delay so the final byte can be flagged
    logic             held_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            cnt_q       <= '0;
            sum_q       <= '0;
            err_q       <= 1'b0;
            held_q      <= '0;
            held_v_q    <= 1'b0;
            out_byte_o  <= '0;
            out_valid_o <= 1'b0;
            out_last_o  <= 1'b0;
            eof_valid_o <= 1'b0;
            eof_len_o   <= '0;
            eof_good_o  <= 1'b0;
        end else begin
            out_valid_o <= 1'b0;
            out_last_o  <= 1'b0;
            eof_valid_o <= 1'b0;
            if (dec_i.eof) begin
                if (st_q == ST_ACCEPT) begin
                    out_valid_o <= held_v_q;
                    out_byte_o  <= held_q;
                    out_last_o  <= held_v_q;
                    eof_valid_o <= 1'b1;
                    eof_len_o   <= cnt_q;
                    eof_good_o  <= (sum_q == 8'h00) && !err_q && !dec_i.bad
                                   && (cnt_q >= LEN_MIN);
                end
                st_q     <= ST_IDLE;
                cnt_q    <= '0;
                sum_q    <= '0;
                err_q    <= 1'b0;
                held_v_q <= 1'b0;
            end else if (dec_i.bad) begin
                if (st_q == ST_IDLE)        st_q  <= ST_SKIP;
                else if (st_q == ST_ACCEPT) err_q <= 1'b1;
            end else if (dec_i.vld) begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (addr_hit(dec_i.data, node_addr, BCAST_ADDR)) begin
                            st_q     <= ST_ACCEPT;
                            cnt_q    <= LEN_ONE;
                            sum_q    <= dec_i.data;
                            held_q   <= dec_i.data;
                            held_v_q <= 1'b1;
                        end else begin
                            st_q <= ST_SKIP;
                        end
                    end
                    ST_ACCEPT: begin
                        out_valid_o <= 1'b1;
                        out_byte_o  <= held_q;
                        if (cnt_q == LEN_CAP) begin
                            // over-length: close now, drop the rest
                            out_last_o  <= 1'b1;
                            eof_valid_o <= 1'b1;
                            eof_len_o   <= cnt_q;
                            eof_good_o  <= 1'b0;
                            held_v_q    <= 1'b0;
                            st_q        <= ST_SKIP;
                        end else begin
                            held_q <= dec_i.data;
                            cnt_q  <= cnt_q + LEN_ONE;
                            sum_q  <= sum_q + dec_i.data;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SKIP && !dec_i.eof) |=> (!out_valid_o && !eof_valid_o)); // R8
    AST_EMPTY_FRAME: assert property (@(posedge clk) disable iff (rst)
        (dec_i.eof && st_q == ST_IDLE) |=> !eof_valid_o); // R2
    AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
        eof_valid_o |-> (eof_len_o <= LEN_CAP)); // R11
    AST_GOOD_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
        (eof_valid_o && eof_good_o) |-> (eof_len_o >= LEN_MIN)); // R10
    AST_LAST_HAS_REPORT: assert property (@(posedge clk) disable iff (rst)
        out_last_o |-> (eof_valid_o && out_valid_o)); // R6

endmodule

// File: rtl/slip_addr_filter.sv
module slip_addr_filter
    import sdf_pkg::*;
#(
    parameter int         MAX_LEN    = 64,
    parameter logic [7:0] BCAST_ADDR = 8'hFF,
    localparam int        LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       node_addr,
    input  logic [7:0]       rx_byte,
    input  logic             rx_valid,
    output logic [7:0]       dout_byte,
    output logic             dout_valid,
    output logic             dout_last,
    output logic             frm_done,
    output logic [LEN_W-1:0] frm_len,
    output logic             frm_ok
);

    dec_t dec;

    sdf_unescape u_unesc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_byte  (rx_byte),
        .dec_o    (dec)
    );

    sdf_filter #(
        .MAX_LEN    (MAX_LEN),
        .BCAST_ADDR (BCAST_ADDR),
        .LEN_W      (LEN_W)
    ) u_filt (
        .clk         (clk),
        .rst         (rst),
        .node_addr   (node_addr),
        .dec_i       (dec),
        .out_byte_o  (dout_byte),
        .out_valid_o (dout_valid),
        .out_last_o  (dout_last),
        .eof_valid_o (frm_done),
        .eof_len_o   (frm_len),
        .eof_good_o  (frm_ok)
    );

endmodule

// File: tb/slip_addr_filter_bench.sv
module slip_addr_filter_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         MAXL       = 8;
    localparam int         LW         = $clog2(MAXL + 1);
    localparam logic [7:0] MY_ADDR    = 8'h5A;
    localparam int         WDOG       = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    node_addr = MY_ADDR;
    logic [7:0]    rx_byte = '0;
    logic          rx_valid = 1'b0;
    logic [7:0]    dout_byte;
    logic          dout_valid, dout_last, frm_done, frm_ok;
    logic [LW-1:0] frm_len;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] fr [32];
    logic [7:0] got [$];
    int n_eof, n_last, last_idx, e_len;
    logic e_good;

    always #(CLK_PERIOD/2) clk = ~clk;

    slip_addr_filter #(.MAX_LEN(MAXL), .BCAST_ADDR(8'hFF)) u_slip_addr_filter (
        .clk(clk), .rst(rst), .node_addr(node_addr),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .dout_byte(dout_byte), .dout_valid(dout_valid), .dout_last(dout_last),
        .frm_done(frm_done), .frm_len(frm_len), .frm_ok(frm_ok)
    );

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (dout_valid) got.push_back(dout_byte);
            if (dout_last) begin
                n_last++;
                last_idx = got.size() - 1;
            end
            if (frm_done) begin
                n_eof++;
                e_len  = int'(frm_len);
                e_good = frm_ok;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        got.delete();
        n_eof = 0; n_last = 0; last_idx = -1; e_len = -1; e_good = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(input int n);
        push(8'hC0);
        for (int i = 0; i < n; i++) begin
            if (fr[i] == 8'hC0)      begin push(8'hDB); push(8'hDC); end
            else if (fr[i] == 8'hDB) begin push(8'hDB); push(8'hDD); end
            else                     push(fr[i]);
        end
        push(8'hC0);
        idle(5);
    endtask

    task automatic check_result(input int xeof, input int xnb, input int xlen,
                                input bit xgood, input string tag);
        int mism;
        chk(n_eof == xeof, {tag, " report count"}, n_eof, xeof);
        chk(got.size() == xnb, {tag, " byte count"}, got.size(), xnb);
        mism = 0;
        for (int i = 0; i < xnb && i < got.size(); i++)
            if (got[i] !== fr[i]) mism++;
        chk(mism == 0, {tag, " byte mismatches"}, mism, 0);
        if (xeof == 1) begin
            chk(e_len == xlen, {tag, " length"}, e_len, xlen);
            chk(e_good == xgood, {tag, " good flag"}, int'(e_good), int'(xgood));
            chk(n_last == 1 && last_idx == xnb - 1, {tag, " last position"},
                last_idx, xnb - 1);
        end
    endtask

    // reference model of the requirements for a cleanly escaped frame
    task automatic verify(input int n, input string tag);
        logic [7:0] s;
        bit acc;
        s = 8'h00;
        for (int i = 0; i < n; i++) s = s + fr[i];
        acc = (n > 0) && (fr[0] == MY_ADDR || fr[0] == 8'hFF);
        if (!acc)          check_result(0, 0, 0, 1'b0, tag);
        else if (n > MAXL) check_result(1, MAXL, MAXL, 1'b0, tag);
        else               check_result(1, n, n, (s == 8'h00) && (n >= 3), tag);
    endtask

    function automatic logic [7:0] neg_sum(input int upto);
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < upto; i++) s = s + fr[i];
        return 8'h00 - s;
    endfunction

    initial begin
        string tag;
        clear_mon();
        // R1: reset state
        idle(2);
        chk(!dout_valid && !dout_last && !frm_done, "R1 outputs in reset",
            int'({dout_valid, dout_last, frm_done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!dout_valid && !dout_last && !frm_done, "R1 outputs after reset",
            int'({dout_valid, dout_last, frm_done}), 0);

        // R2: runs of delimiters are empty frames
        clear_mon();
        push(8'hC0); push(8'hC0); push(8'hC0); push(8'hC0);
        idle(5);
        chk(n_eof == 0 && got.size() == 0, "R2 empty frames silent",
            n_eof + got.size(), 0);

        // R6/R7/R8: destination sweep over every value
        for (int a = 0; a < 256; a++) begin
            fr[0] = 8'(a); fr[1] = 8'h11; fr[2] = 8'h22; fr[3] = neg_sum(3);
            clear_mon();
            send_frame(4);
            if (a == int'(MY_ADDR)) tag = "R6 node addr";
            else if (a == 255)      tag = "R7 broadcast";
            else                    tag = "R8 foreign addr";
            verify(4, tag);
        end

        // R3/R4: data bytes needing escapes
        fr[0] = MY_ADDR; fr[1] = 8'hC0; fr[2] = 8'hDB; fr[3] = 8'hC0;
        fr[4] = 8'hDB; fr[5] = neg_sum(5);
        clear_mon();
        send_frame(6);
        verify(6, "R3 R4 escaped data");

        // R9/R10/R11: length sweep, good and corrupted check byte
        for (int n = 1; n <= MAXL + 3; n++) begin
            for (int flip = 0; flip < 2; flip++) begin
                fr[0] = MY_ADDR;
                for (int i = 1; i < n; i++) fr[i] = 8'(i * 37 + 5);
                if (n >= 2) fr[n-1] = neg_sum(n - 1);
                if (flip == 1) fr[n-1] = fr[n-1] ^ 8'h01;
                if (n < 3)         tag = "R10 short frame";
                else if (n > MAXL) tag = "R11 over length";
                else               tag = "R9 check sum";
                clear_mon();
                send_frame(n);
                verify(n, tag);
            end
        end

        // R5: illegal escape pair inside an accepted frame
        fr[0] = MY_ADDR; fr[1] = 8'h01; fr[2] = neg_sum(2);
        clear_mon();
        push(8'hC0); push(fr[0]); push(fr[1]); push(8'hDB); push(8'h41);
        push(fr[2]); push(8'hC0);
        idle(5);
        check_result(1, 3, 3, 1'b0, "R5 bad escape");

        // R5: escape cut short by the delimiter
        clear_mon();
        push(8'hC0); push(fr[0]); push(fr[1]); push(fr[2]); push(8'hDB);
        push(8'hC0);
        idle(5);
        check_result(1, 3, 3, 1'b0, "R5 escape before end");

        // R2: after frames, a lone delimiter stays silent
        clear_mon();
        push(8'hC0);
        idle(5);
        chk(n_eof == 0, "R2 lone delimiter", n_eof, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < WDOG; c++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule